// File: doc/BRIEF.md
# DMA Channel Run-State Controller

This block holds the run state of a single DMA channel and decides, cycle by cycle, whether the channel is idle, moving data, or parked between descriptors. Software control writes arrive as a one-cycle strobe carrying four control bits: enable, continue, continue-from-start and descriptor-pointer mode. The transfer engine reports back with a descriptor-complete handshake tagged by the command code held in that descriptor, and with a fetch-error pulse.

In return the controller launches each descriptor with a one-cycle run strobe. It asks the pointer logic either to reload the current-descriptor pointers from the programmed start values or to step to the next descriptor. It raises one-cycle done and pause events for the interrupt logic and publishes a 2-bit status code. The enable and continue bits clear themselves on the events that consume them, and both are visible as outputs.

Top module: `chan_run_ctrl`

## Requirements
- R1: After reset the status is 0, the enable and continue bits are 0 and every event output is 0. The status reads 0 when disabled, 1 when enabled and 2 when paused. It reads 3 whenever the error flag is set, whatever the state.
- R2: A control write with enable=1 while disabled does the following. It clears the error flag and pulses load_start_o and run_o in the following cycle. The status becomes 1.
- R3: A control write with enable=1 and continue=1 while paused resumes the channel. The status becomes 1, run_o pulses and the continue bit reads 0 afterwards. With continue-from-start=1, load_start_o pulses and next_desc_o stays low. With continue-from-start=0, next_desc_o pulses and load_start_o stays low.
- R4: A control write with enable=1 and continue=0 while paused leaves the channel paused and produces no run, load or advance pulse.
- R5: A control write with enable=0 and continue=1 while paused moves the channel to disabled. A control write with enable=0 while enabled leaves the state unchanged.
- R6: A descriptor completion with command code 2 (stop) returns the channel to disabled and clears the enable bit. Any completion in register-pointer mode (ctl_mem_ptr_i=0) does the same, whatever its command.
- R7: In memory-pointer mode, a descriptor completion with command code 1 (halt) enters paused and pulses pause_evt_o. The enable bit stays 1.
- R8: In memory-pointer mode, a descriptor completion with command code 0 or 3 pulses next_desc_o and run_o together and keeps the channel enabled.
- R9: done_evt_o pulses once for every descriptor completion accepted while the channel is enabled and waiting. A completion that arrives while the channel is disabled or paused is ignored.
- R10: A fetch-error pulse forces the channel to disabled and sets the error flag, so the status reads 3. Completions are then ignored until a new enable write.
- R11: Every event output is registered. It is high for exactly one cycle, in the cycle after the clock edge that sampled its cause.

Ports listed in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_i | input | 1 | One-cycle control write strobe |
| ctl_en_i | input | 1 | Written enable bit |
| ctl_cont_i | input | 1 | Written continue bit |
| ctl_from_start_i | input | 1 | Written continue-from-start bit |
| ctl_mem_ptr_i | input | 1 | Written pointer mode: 1 = descriptors in memory, 0 = register descriptor |
| fetch_err_i | input | 1 | Descriptor fetch error pulse |
| desc_cplt_i | input | 1 | Descriptor-complete handshake from the transfer engine |
| desc_cmd_i | input | CMD_W | Command code of the completed descriptor |
| status_o | output | 2 | Status code: 0 disabled, 1 enabled, 2 paused, 3 error |
| en_o | output | 1 | Current enable bit |
| cont_o | output | 1 | Current continue bit |
| load_start_o | output | 1 | Pulse: copy start pointers into current-descriptor pointers |
| next_desc_o | output | 1 | Pulse: step the source descriptor pointer to the next descriptor |
| run_o | output | 1 | Pulse: launch the current descriptor |
| pause_evt_o | output | 1 | Pause interrupt event |
| done_evt_o | output | 1 | Descriptor done interrupt event |

## Verification
A corrupted run state is visible on status_o one cycle after the edge that produced it, because the code is decoded straight from the state and error flops. A wrong branch on a completion shows up in the following cycle. It appears either as a missing or extra run, advance or load pulse, or as a pause event without the paused code. Stale control bits show on en_o and cont_o after a stop or a resume. Each such slip therefore surfaces at the ports within one cycle of its cause.

// File: rtl/chan_run_pkg.sv
package chan_run_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } run_state_e;

  localparam logic [1:0] STATUS_FAULT = 2'd3;
  localparam int unsigned HALT_CODE = 1;
  localparam int unsigned STOP_CODE = 2;
endpackage

// File: rtl/chan_ctl_bits.sv
module chan_ctl_bits (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic en_i,
  input  logic cont_i,
  input  logic from_start_i,
  input  logic mem_ptr_i,
  input  logic clr_en_i,
  input  logic clr_cont_i,
  input  logic set_err_i,
  input  logic clr_err_i,
  output logic en_q_o,
  output logic cont_q_o,
  output logic err_q_o,
  output logic en_eff_o,
  output logic cont_eff_o,
  output logic from_start_eff_o,
  output logic mem_ptr_eff_o
);
  logic en_q, cont_q, fs_q, mem_q, err_q;

  // Values seen by the state machine: a write takes effect in its own cycle
  assign en_eff_o         = wr_i ? en_i         : en_q;
  assign cont_eff_o       = wr_i ? cont_i       : cont_q;
  assign from_start_eff_o = wr_i ? from_start_i : fs_q;
  assign mem_ptr_eff_o    = wr_i ? mem_ptr_i    : mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      cont_q <= 1'b0;
      fs_q   <= 1'b0;
      mem_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        en_q   <= en_i;
        cont_q <= cont_i;
        fs_q   <= from_start_i;
        mem_q  <= mem_ptr_i;
      end
      if (clr_en_i)   en_q   <= 1'b0;
      if (clr_cont_i) cont_q <= 1'b0;
      if (set_err_i)      err_q <= 1'b1;
      else if (clr_err_i) err_q <= 1'b0;
    end
  end

  assign en_q_o   = en_q;
  assign cont_q_o = cont_q;
  assign err_q_o  = err_q;
endmodule

// File: rtl/chan_run_fsm.sv
module chan_run_fsm #(
  parameter int CMD_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_i,
  input  logic                      en_i,
  input  logic                      cont_i,
  input  logic                      from_start_i,
  input  logic                      mem_ptr_i,
  input  logic                      err_q_i,
  input  logic                      fetch_err_i,
  input  logic                      cplt_i,
  input  logic [CMD_W-1:0]          cmd_i,
  output chan_run_pkg::run_state_e  state_o,
  output logic                      clr_en_o,
  output logic                      clr_cont_o,
  output logic                      set_err_o,
  output logic                      clr_err_o,
  output logic                      load_o,
  output logic                      adv_o,
  output logic                      run_o,
  output logic                      pause_o,
  output logic                      done_o
);
  import chan_run_pkg::*;

  localparam logic [CMD_W-1:0] CMD_HALT = CMD_W'(HALT_CODE);
  localparam logic [CMD_W-1:0] CMD_STOP = CMD_W'(STOP_CODE);

  run_state_e state_q, state_n;
  logic busy_q, busy_n;
  logic load_n, adv_n, run_n, pause_n, done_n;

  always_comb begin
    state_n    = state_q;
    busy_n     = busy_q;
    load_n     = 1'b0;
    adv_n      = 1'b0;
    run_n      = 1'b0;
    pause_n    = 1'b0;
    done_n     = 1'b0;
    clr_en_o   = 1'b0;
    clr_cont_o = 1'b0;
    set_err_o  = 1'b0;
    clr_err_o  = 1'b0;
    if (fetch_err_i) begin
      set_err_o = 1'b1;
      state_n   = ST_OFF;
      busy_n    = 1'b0;
    end else if (state_q == ST_RUN) begin
      if (busy_q && cplt_i) begin
        done_n = 1'b1;
        busy_n = 1'b0;
        if (!mem_ptr_i || cmd_i == CMD_STOP) begin
          clr_en_o = 1'b1;
          state_n  = ST_OFF;
        end else if (cmd_i == CMD_HALT) begin
          state_n = ST_HOLD;
          pause_n = 1'b1;
        end else begin
          adv_n  = 1'b1;
          run_n  = 1'b1;
          busy_n = 1'b1;
        end
      end
    end else if (wr_i) begin
      if (en_i) begin
        if (state_q == ST_OFF) begin
          clr_err_o = 1'b1;
          load_n    = 1'b1;
          run_n     = 1'b1;
          busy_n    = 1'b1;
          state_n   = ST_RUN;
        end else if (cont_i) begin
          clr_cont_o = 1'b1;
          load_n     = from_start_i;
          adv_n      = !from_start_i;
          run_n      = 1'b1;
          busy_n     = 1'b1;
          state_n    = ST_RUN;
        end
      end else if (state_q == ST_HOLD && cont_i) begin
        state_n = ST_OFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      busy_q  <= 1'b0;
      load_o  <= 1'b0;
      adv_o   <= 1'b0;
      run_o   <= 1'b0;
      pause_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_n;
      busy_q  <= busy_n;
      load_o  <= load_n;
      adv_o   <= adv_n;
      run_o   <= run_n;
      pause_o <= pause_n;
      done_o  <= done_n;
    end
  end

  assign state_o = state_q;

  assert_run_only_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    run_o |-> state_q == ST_RUN);
  assert_pause_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
    pause_o |-> state_q == ST_HOLD);
  assert_error_means_off_R10: assert property (@(posedge clk) disable iff (rst)
    err_q_i |-> state_q == ST_OFF);
  assert_load_adv_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(load_o && adv_o));
  assert_stop_goes_off_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && busy_q && cplt_i && !fetch_err_i && cmd_i == CMD_STOP)
      |=> (state_q == ST_OFF && done_o));
  assert_halt_goes_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && busy_q && cplt_i && !fetch_err_i && mem_ptr_i && cmd_i == CMD_HALT)
      |=> (state_q == ST_HOLD && pause_o));
  assert_done_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(cplt_i));
endmodule

// File: rtl/chan_status_enc.sv
module chan_status_enc (
  input  chan_run_pkg::run_state_e state_i,
  input  logic                     err_i,
  output logic [1:0]               status_o
);
  import chan_run_pkg::*;
  assign status_o = err_i ? STATUS_FAULT : 2'(state_i);
endmodule

// File: rtl/chan_run_ctrl.sv
module chan_run_ctrl #(
  parameter int CMD_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr_i,
  input  logic             ctl_en_i,
  input  logic             ctl_cont_i,
  input  logic             ctl_from_start_i,
  input  logic             ctl_mem_ptr_i,
  input  logic             fetch_err_i,
  input  logic             desc_cplt_i,
  input  logic [CMD_W-1:0] desc_cmd_i,
  output logic [1:0]       status_o,
  output logic             en_o,
  output logic             cont_o,
  output logic             load_start_o,
  output logic             next_desc_o,
  output logic             run_o,
  output logic             pause_evt_o,
  output logic             done_evt_o
);
  import chan_run_pkg::*;

  logic en_eff, cont_eff, fs_eff, mem_eff, err_q;
  logic clr_en, clr_cont, set_err, clr_err;
  run_state_e state;

  chan_ctl_bits u_bits (
    .clk(clk), .rst(rst),
    .wr_i(ctl_wr_i), .en_i(ctl_en_i), .cont_i(ctl_cont_i),
    .from_start_i(ctl_from_start_i), .mem_ptr_i(ctl_mem_ptr_i),
    .clr_en_i(clr_en), .clr_cont_i(clr_cont),
    .set_err_i(set_err), .clr_err_i(clr_err),
    .en_q_o(en_o), .cont_q_o(cont_o), .err_q_o(err_q),
    .en_eff_o(en_eff), .cont_eff_o(cont_eff),
    .from_start_eff_o(fs_eff), .mem_ptr_eff_o(mem_eff)
  );

  chan_run_fsm #(.CMD_W(CMD_W)) u_fsm (
    .clk(clk), .rst(rst),
    .wr_i(ctl_wr_i), .en_i(en_eff), .cont_i(cont_eff),
    .from_start_i(fs_eff), .mem_ptr_i(mem_eff), .err_q_i(err_q),
    .fetch_err_i(fetch_err_i), .cplt_i(desc_cplt_i), .cmd_i(desc_cmd_i),
    .state_o(state),
    .clr_en_o(clr_en), .clr_cont_o(clr_cont),
    .set_err_o(set_err), .clr_err_o(clr_err),
    .load_o(load_start_o), .adv_o(next_desc_o), .run_o(run_o),
    .pause_o(pause_evt_o), .done_o(done_evt_o)
  );

  chan_status_enc u_enc (
    .state_i(state), .err_i(err_q), .status_o(status_o)
  );
endmodule

// File: tb/tb_chan_run_ctrl.sv
`timescale 1ns/1ps
module tb_chan_run_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr_i = 0, ctl_en_i = 0, ctl_cont_i = 0, ctl_from_start_i = 0, ctl_mem_ptr_i = 0;
  logic fetch_err_i = 0, desc_cplt_i = 0;
  logic [1:0] desc_cmd_i = 0;
  logic [1:0] status_o;
  logic en_o, cont_o, load_start_o, next_desc_o, run_o, pause_evt_o, done_evt_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chan_run_ctrl dut (
    .clk(clk), .rst(rst),
    .ctl_wr_i(ctl_wr_i), .ctl_en_i(ctl_en_i), .ctl_cont_i(ctl_cont_i),
    .ctl_from_start_i(ctl_from_start_i), .ctl_mem_ptr_i(ctl_mem_ptr_i),
    .fetch_err_i(fetch_err_i), .desc_cplt_i(desc_cplt_i), .desc_cmd_i(desc_cmd_i),
    .status_o(status_o), .en_o(en_o), .cont_o(cont_o),
    .load_start_o(load_start_o), .next_desc_o(next_desc_o), .run_o(run_o),
    .pause_evt_o(pause_evt_o), .done_evt_o(done_evt_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // events packed as {load, adv, run, pause, done}
  function automatic int evts();
    return {27'd0, load_start_o, next_desc_o, run_o, pause_evt_o, done_evt_o};
  endfunction

  task automatic ctl_write(input logic en, input logic cont, input logic fs, input logic mem);
    ctl_wr_i = 1; ctl_en_i = en; ctl_cont_i = cont; ctl_from_start_i = fs; ctl_mem_ptr_i = mem;
    @(negedge clk);
    ctl_wr_i = 0;
  endtask

  task automatic complete(input logic [1:0] cmd);
    desc_cplt_i = 1; desc_cmd_i = cmd;
    @(negedge clk);
    desc_cplt_i = 0; desc_cmd_i = 0;
  endtask

  task automatic fetch_error();
    fetch_err_i = 1;
    @(negedge clk);
    fetch_err_i = 0;
  endtask

  task automatic t_reset();
    check("R1 status", status_o, 0);
    check("R1 en", en_o, 0);
    check("R1 cont", cont_o, 0);
    check("R1 events", evts(), 0);
  endtask

  task automatic t_start_and_advance();
    ctl_write(1, 0, 0, 1);
    check("R2 events load+run", evts(), 5'b10100);
    check("R2 status", status_o, 1);
    check("R2 en", en_o, 1);
    @(negedge clk);
    check("R11 pulses single cycle", evts(), 0);
    complete(2'd0);
    check("R8 cmd0 adv+run+done", evts(), 5'b01101);
    check("R8 status", status_o, 1);
    complete(2'd3);
    check("R8 cmd3 adv+run+done", evts(), 5'b01101);
    @(negedge clk);
    check("R11 idle after advance", evts(), 0);
  endtask

  task automatic t_halt_and_resume();
    complete(2'd1);
    check("R7 pause+done", evts(), 5'b00011);
    check("R7 status paused", status_o, 2);
    check("R7 en kept", en_o, 1);
    complete(2'd0);
    check("R9 ignored while paused", evts(), 0);
    check("R9 status unchanged", status_o, 2);
    ctl_write(1, 0, 0, 1);
    check("R4 no pulses", evts(), 0);
    check("R4 still paused", status_o, 2);
    ctl_write(1, 1, 0, 1);
    check("R3 adv+run", evts(), 5'b01100);
    check("R3 status", status_o, 1);
    check("R3 cont cleared", cont_o, 0);
    complete(2'd1);
    check("R7 second halt", status_o, 2);
    ctl_write(1, 1, 1, 1);
    check("R3 from start load+run", evts(), 5'b10100);
    check("R3 cont cleared again", cont_o, 0);
  endtask

  task automatic t_stop();
    complete(2'd2);
    check("R6 stop done only", evts(), 5'b00001);
    check("R6 status off", status_o, 0);
    check("R6 en cleared", en_o, 0);
  endtask

  task automatic t_reg_mode();
    ctl_write(1, 0, 0, 0);
    check("R2 reg-mode start", evts(), 5'b10100);
    complete(2'd0);
    check("R6 reg mode done only", evts(), 5'b00001);
    check("R6 reg mode off", status_o, 0);
    check("R6 reg mode en cleared", en_o, 0);
    complete(2'd0);
    check("R9 ignored while off", evts(), 0);
  endtask

  task automatic t_leave_pause();
    ctl_write(1, 0, 0, 1);
    ctl_write(0, 0, 0, 1);
    check("R5 en=0 while running keeps state", status_o, 1);
    complete(2'd1);
    check("R7 paused", status_o, 2);
    ctl_write(0, 1, 0, 1);
    check("R5 exit pause", status_o, 0);
    check("R5 no pulses", evts(), 0);
  endtask

  task automatic t_error();
    ctl_write(1, 0, 0, 1);
    fetch_error();
    check("R10 status error", status_o, 3);
    check("R10 no events", evts(), 0);
    complete(2'd0);
    check("R10 completion ignored", evts(), 0);
    check("R1 status stays 3", status_o, 3);
    ctl_write(1, 0, 0, 1);
    check("R2 error cleared", status_o, 1);
    check("R2 restart load+run", evts(), 5'b10100);
    complete(2'd2);
    check("R6 final stop", status_o, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_start_and_advance();
    t_halt_and_resume();
    t_stop();
    t_reg_mode();
    t_leave_pause();
    t_error();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule